// File: doc/BRIEF.md
# Multi-Mode PWM Input Decoder

This block turns the six PWM request pins of a three-phase bridge into six registered gate requests: one high-side and one low-side request for each phase. It also reports, for each phase, when the switch node is left floating. The way the pins are read depends on a 2-bit control mode.

In complementary mode each phase has a high pin and a low pin, and both pins high counts as invalid. In enable mode the low pin gates the phase and the high pin picks which side conducts. In independent mode every pin drives its own gate with no interlock. The remaining code hands the gates to a separate commutation block, whose six requests pass through unchanged.

The mode comes from a configuration register. The block accepts a new mode only on a clock edge where all six PWM pins are low. Until then it keeps running in the old mode and raises a pending flag. All pins here are plain control and status signals. The block has no streaming interface, so no back-pressure rules apply.

Top module: `pwm_in_decoder`

## Requirements
- R1: `mode_sel` is encoded as 2'b00 complementary, 2'b01 enable, 2'b10 commutation pass-through and 2'b11 independent. `mode_act` shows the mode in effect and resets to 2'b00.
- R2: In complementary mode (00), each phase i behaves as follows. `in_hi[i]`=1 with `in_lo[i]`=0 requests only the high gate. `in_lo[i]`=1 with `in_hi[i]`=0 requests only the low gate. Both pins 0, or both pins 1, turn both gates off.
- R3: In enable mode (01), `in_lo[i]`=0 turns both gates of phase i off, whatever the value of `in_hi[i]`. With `in_lo[i]`=1, `in_hi[i]`=1 requests the high gate and `in_hi[i]`=0 requests the low gate.
- R4: In independent mode (11), `gate_hi[i]` follows `in_hi[i]` and `gate_lo[i]` follows `in_lo[i]`. Both gates on at once is allowed.
- R5: In commutation mode (10), `gate_hi` equals `comm_hi`, `gate_lo` equals `comm_lo` and `hiz` is 0. The PWM pins have no effect on the gates in this mode.
- R6: If any of the six PWM pins is high at a clock edge, `mode_act` keeps its value at that edge, whatever `mode_sel` holds.
- R7: `mode_pend` is 1 after a clock edge at which any PWM pin was high and `mode_sel` differed from `mode_act`. After any other edge it is 0.
- R8: In modes 00 and 01, `hiz[i]` is 1 exactly when both gate requests of phase i are off. In modes 10 and 11, `hiz` is 0.
- R9: Outputs are registered and reflect the inputs sampled at the previous rising edge. A synchronous `rst` forces all gate requests off, `hiz` to all ones, `mode_act` to 00 and `mode_pend` to 0.
- R10: On a clock edge where all PWM pins are low, `mode_sel` is taken in, and the outputs registered at that same edge are already decoded in the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Requested mode from the configuration register |
| in_hi | input | 3 | High-side PWM pin per phase |
| in_lo | input | 3 | Low-side PWM pin per phase |
| comm_hi | input | 3 | High gate requests from the commutation block |
| comm_lo | input | 3 | Low gate requests from the commutation block |
| gate_hi | output | 3 | Registered high gate request per phase |
| gate_lo | output | 3 | Registered low gate request per phase |
| hiz | output | 3 | Phase left floating |
| mode_act | output | 2 | Mode in effect |
| mode_pend | output | 1 | A requested mode change is waiting for idle pins |

## Verification
The hardest situation to reach is a mode request that arrives while the bridge is active. To set it up, the stimulus leaves a phase switching in independent mode and then moves `mode_sel` to complementary. It checks that the gates keep following the independent table and that `mode_pend` rises. It then drops all six pins and checks that the new mode lands on that idle edge. A second directed case shows that the idle edge itself already decodes in the new mode, by switching to commutation with `comm_hi` set during the idle edge.

// File: rtl/pwm_dec_pkg.sv
package pwm_dec_pkg;
  typedef enum logic [1:0] {
    MD_CMPL  = 2'b00,
    MD_ENA   = 2'b01,
    MD_COMM  = 2'b10,
    MD_INDEP = 2'b11
  } drv_mode_e;
endpackage

// File: rtl/pwm_mode_gate.sv
module pwm_mode_gate
  import pwm_dec_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic [1:0] mode_sel,
  input  logic      pins_idle,
  output drv_mode_e mode_eff,
  output drv_mode_e mode_q,
  output logic      pend_q
);
  // a new request is only taken on an idle edge
  always_comb begin
    if (pins_idle) mode_eff = drv_mode_e'(mode_sel);
    else           mode_eff = mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_CMPL;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_eff;
      pend_q <= !pins_idle && (mode_sel != mode_q);
    end
  end
endmodule

// File: rtl/pwm_phase_map.sv
module pwm_phase_map
  import pwm_dec_pkg::*;
(
  input  drv_mode_e mode,
  input  logic      pin_hi,
  input  logic      pin_lo,
  input  logic      cm_hi,
  input  logic      cm_lo,
  output logic      req_hi,
  output logic      req_lo,
  output logic      float_o
);
  always_comb begin
    req_hi  = 1'b0;
    req_lo  = 1'b0;
    float_o = 1'b0;
    unique case (mode)
      MD_CMPL: begin
        req_hi  = pin_hi & ~pin_lo;
        req_lo  = pin_lo & ~pin_hi;
        float_o = ~(pin_hi ^ pin_lo);
      end
      MD_ENA: begin
        req_hi  = pin_lo & pin_hi;
        req_lo  = pin_lo & ~pin_hi;
        float_o = ~pin_lo;
      end
      MD_COMM: begin
        req_hi = cm_hi;
        req_lo = cm_lo;
      end
      MD_INDEP: begin
        req_hi = pin_hi;
        req_lo = pin_lo;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwm_in_decoder.sv
module pwm_in_decoder
  import pwm_dec_pkg::*;
#(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     mode_sel,
  input  logic [NPH-1:0] in_hi,
  input  logic [NPH-1:0] in_lo,
  input  logic [NPH-1:0] comm_hi,
  input  logic [NPH-1:0] comm_lo,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo,
  output logic [NPH-1:0] hiz,
  output logic [1:0]     mode_act,
  output logic           mode_pend
);
  localparam int NPIN = 2 * NPH;

  logic [NPIN-1:0] pins;
  logic            pins_idle;
  drv_mode_e       mode_eff;
  drv_mode_e       mode_q;
  logic [NPH-1:0]  nx_hi, nx_lo, nx_z;

  assign pins      = {in_hi, in_lo};
  assign pins_idle = (pins == '0);

  pwm_mode_gate u_mode (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .pins_idle(pins_idle),
    .mode_eff (mode_eff),
    .mode_q   (mode_q),
    .pend_q   (mode_pend)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    pwm_phase_map u_map (
      .mode   (mode_eff),
      .pin_hi (in_hi[p]),
      .pin_lo (in_lo[p]),
      .cm_hi  (comm_hi[p]),
      .cm_lo  (comm_lo[p]),
      .req_hi (nx_hi[p]),
      .req_lo (nx_lo[p]),
      .float_o(nx_z[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi <= '0;
      gate_lo <= '0;
      hiz     <= '1;
    end else begin
      gate_hi <= nx_hi;
      gate_lo <= nx_lo;
      hiz     <= nx_z;
    end
  end

  assign mode_act = mode_q;
endmodule

// File: rtl/pwm_in_decoder_chk.sv
module pwm_in_decoder_chk #(
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     mode_sel,
  input logic [NPH-1:0] in_hi,
  input logic [NPH-1:0] in_lo,
  input logic [NPH-1:0] gate_hi,
  input logic [NPH-1:0] gate_lo,
  input logic [NPH-1:0] hiz,
  input logic [1:0]     mode_act,
  input logic           mode_pend
);
  logic busy;
  assign busy = (in_hi != '0) || (in_lo != '0);

  a_r6_mode_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> mode_act == $past(mode_act));

  a_r7_pend_set: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_sel != mode_act) |=> mode_pend);

  a_r4_indep_follow: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_act == 2'b11) |=> (gate_hi == $past(in_hi)) && (gate_lo == $past(in_lo)));

  for (genvar p = 0; p < NPH; p++) begin : g_pc
    a_r2_both_high_off: assert property (@(posedge clk) disable iff (rst)
      (mode_act == 2'b00 && in_hi[p] && in_lo[p]) |=> (!gate_hi[p] && !gate_lo[p] && hiz[p]));

    a_r3_enable_low_off: assert property (@(posedge clk) disable iff (rst)
      (busy && mode_act == 2'b01 && !in_lo[p]) |=> (!gate_hi[p] && !gate_lo[p] && hiz[p]));

    a_r8_hiz_means_off: assert property (@(posedge clk) disable iff (rst)
      hiz[p] |-> (!gate_hi[p] && !gate_lo[p]));
  end
endmodule

bind pwm_in_decoder pwm_in_decoder_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .in_hi(in_hi), .in_lo(in_lo),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .hiz(hiz), .mode_act(mode_act),
  .mode_pend(mode_pend)
);

// File: tb/sim_pwm_in_decoder.sv
module sim_pwm_in_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic [2:0] in_hi = '0, in_lo = '0, comm_hi = '0, comm_lo = '0;
  logic [2:0] gate_hi, gate_lo, hiz;
  logic [1:0] mode_act;
  logic       mode_pend;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  pwm_in_decoder u0 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .in_hi(in_hi), .in_lo(in_lo),
    .comm_hi(comm_hi), .comm_lo(comm_lo), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .hiz(hiz), .mode_act(mode_act), .mode_pend(mode_pend)
  );

  // {mode, hi, lo, comm_hi, comm_lo, exp_hi, exp_lo, exp_hiz}
  localparam int NV = 11;
  localparam logic [22:0] VEC [NV] = '{
    {2'b00, 3'b010, 3'b100, 3'b000, 3'b000, 3'b010, 3'b100, 3'b001},
    {2'b00, 3'b111, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000, 3'b111},
    {2'b00, 3'b101, 3'b001, 3'b000, 3'b000, 3'b100, 3'b000, 3'b011},
    {2'b01, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b111},
    {2'b01, 3'b101, 3'b111, 3'b000, 3'b000, 3'b101, 3'b010, 3'b000},
    {2'b01, 3'b010, 3'b011, 3'b000, 3'b000, 3'b010, 3'b001, 3'b100},
    {2'b11, 3'b111, 3'b111, 3'b000, 3'b000, 3'b111, 3'b111, 3'b000},
    {2'b11, 3'b100, 3'b011, 3'b000, 3'b000, 3'b100, 3'b011, 3'b000},
    {2'b10, 3'b001, 3'b000, 3'b010, 3'b101, 3'b010, 3'b101, 3'b000},
    {2'b10, 3'b000, 3'b000, 3'b111, 3'b000, 3'b111, 3'b000, 3'b000},
    {2'b10, 3'b111, 3'b011, 3'b001, 3'b110, 3'b001, 3'b110, 3'b000}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R5";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    // R9 reset state
    chk("R9 gate_hi", 8'(gate_hi), 8'h0);
    chk("R9 gate_lo", 8'(gate_lo), 8'h0);
    chk("R9 hiz", 8'(hiz), 8'h7);
    chk("R1 mode_act", 8'(mode_act), 8'h0);
    chk("R7 pend", 8'(mode_pend), 8'h0);

    for (int v = 0; v < NV; v++) begin
      // idle edge loads the mode (R1)
      mode_sel = VEC[v][22:21];
      in_hi = '0; in_lo = '0; comm_hi = '0; comm_lo = '0;
      tick();
      chk("R1 mode load", 8'(mode_act), 8'(VEC[v][22:21]));
      in_hi   = VEC[v][20:18];
      in_lo   = VEC[v][17:15];
      comm_hi = VEC[v][14:12];
      comm_lo = VEC[v][11:9];
      tick();
      chk({tag_of(VEC[v][22:21]), " gate_hi"}, 8'(gate_hi), 8'(VEC[v][8:6]));
      chk({tag_of(VEC[v][22:21]), " gate_lo"}, 8'(gate_lo), 8'(VEC[v][5:3]));
      chk("R8 hiz", 8'(hiz), 8'(VEC[v][2:0]));
    end

    // R6/R7: request while active in independent mode
    in_hi = '0; in_lo = '0; comm_hi = '0; comm_lo = '0;
    mode_sel = 2'b11;
    tick();
    in_hi = 3'b001; in_lo = 3'b001;
    tick();
    mode_sel = 2'b00;
    tick();
    chk("R6 mode held", 8'(mode_act), 8'h3);
    chk("R7 pend raised", 8'(mode_pend), 8'h1);
    chk("R6 still independent", 8'({gate_hi, gate_lo}), 8'h09);
    in_hi = '0; in_lo = '0;
    tick();
    chk("R1 mode after idle", 8'(mode_act), 8'h0);
    chk("R7 pend cleared", 8'(mode_pend), 8'h0);
    chk("R8 hiz idle six", 8'(hiz), 8'h7);

    // R10: idle edge decodes in the new mode at once
    mode_sel = 2'b10; comm_hi = 3'b100; comm_lo = 3'b010;
    tick();
    chk("R10 gate_hi", 8'(gate_hi), 8'h4);
    chk("R10 gate_lo", 8'(gate_lo), 8'h2);
    chk("R10 hiz", 8'(hiz), 8'h0);

    // R5: PWM pins ignored in commutation mode
    in_hi = 3'b111; in_lo = 3'b101;
    tick();
    chk("R5 pins ignored", 8'({gate_hi, gate_lo}), 8'h22);

    // R9: reset mid-operation
    comm_hi = '0; comm_lo = '0; in_hi = '0; in_lo = '0;
    mode_sel = 2'b11;
    tick();
    in_hi = 3'b111; in_lo = 3'b111;
    tick();
    chk("R4 dual on", 8'({gate_hi, gate_lo}), 8'h3f);
    rst = 1'b1;
    tick();
    chk("R9 reset gates", 8'({gate_hi, gate_lo}), 8'h00);
    chk("R9 reset mode", 8'(mode_act), 8'h0);
    chk("R9 reset hiz", 8'(hiz), 8'h7);
    rst = 1'b0;
    in_hi = '0; in_lo = '0;
    tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule